// File: doc/BRIEF.md
# Stream Requantizer with Round and Clip

This block narrows a wide signed sample stream to a smaller output width. The sample can be real or complex. First it removes a fixed number of low-order bits. It either rounds them away (half away from zero) or drops them. An optional guard keeps a rounding carry from wrapping the result to the negative extreme. Next it reduces the remaining high-order bits. It either saturates them or discards them. Saturation can use the full two's-complement negative limit, or a symmetric limit equal to the negated positive maximum.

All behaviour is chosen by parameters at build time, and nothing can be changed at run time. The real and imaginary lanes share one datapath design, and there is one instance per lane. The valid flag and a free-form sideband word travel alongside the data through the same two register stages, so they stay aligned with the samples they describe. A typical use is after a gain or filter stage, to bring a widened product back to a bus width.

Top module: `stream_requant`

## Requirements
- R1: The output valid is a copy of the input valid delayed by exactly two clock cycles. While reset is high and in the cycles after it, out_valid reads 0 until valid input has travelled through.
- R2: The sideband word leaves with a delay of two cycles, in the same cycle as the sample it was presented with.
- R3: With ROUND=1, the stage that drops bits computes (x + 2^(LSB_W-1)) >> LSB_W for x >= 0 and (x + 2^(LSB_W-1) - 1) >> LSB_W for x < 0, using an arithmetic shift. This rounds halves away from zero.
- R4: With ROUND=0, the dropped bits are discarded by an arithmetic right shift by LSB_W, which rounds toward minus infinity.
- R5: With ROUND=1 and ROUND_HOLD=1, a positive value whose rounding carries past the intermediate width (IN_W-LSB_W bits) is held at the intermediate positive maximum 2^(IN_W-LSB_W-1)-1.
- R6: With ROUND=1 and ROUND_HOLD=0, that carry wraps the intermediate value to its negative extreme -2^(IN_W-LSB_W-1).
- R7: With SAT=1 and SYM=0, intermediate values above 2^(OUT_W-1)-1 leave as 2^(OUT_W-1)-1, and values below -2^(OUT_W-1) leave as -2^(OUT_W-1).
- R8: With SAT=1 and SYM=1, the negative limit is -(2^(OUT_W-1)-1). This covers values that were in range and equal to -2^(OUT_W-1).
- R9: With SAT=0, the output is the low OUT_W bits of the intermediate value, read as two's complement, whatever the value of SYM.
- R10: With COMPLEX=1, the imaginary lane gets exactly the same processing as the real lane, independently of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample valid |
| in_re | input | IN_W | Real (or only) input sample, signed |
| in_im | input | IN_W | Imaginary input sample, signed |
| in_side | input | SIDE_W | Sideband word that travels with the sample |
| out_valid | output | 1 | Output sample valid |
| out_re | output | OUT_W | Requantized real sample, signed |
| out_im | output | OUT_W | Requantized imaginary sample, signed (0 when COMPLEX=0) |
| out_side | output | SIDE_W | Delayed sideband word |

## Verification
Every result (valid, sideband, real and imaginary data) appears two rising edges after the input is captured. The bench drives inputs on the falling edge. On each falling edge it compares the outputs with an expected record that was made two falling edges earlier and moved along a two-entry history. Three instances with different option sets receive the same stimulus, so the round, truncate, hold, wrap, asymmetric and symmetric variants can each be checked against a bench function built from the formulas above.

// File: rtl/rq_pkg.sv
package rq_pkg;

  // Largest positive value of a signed field of width w.
  function automatic longint rq_smax(input int w);
    return (longint'(1) <<< (w - 1)) - 1;
  endfunction

  // Number of datapath lanes for a real or complex stream.
  function automatic int rq_lanes(input bit cplx);
    return cplx ? 2 : 1;
  endfunction

endpackage

// File: rtl/rq_lsb.sv
module rq_lsb #(
  parameter int IN_W       = 16,
  parameter int LSB_W      = 4,
  parameter bit ROUND      = 1'b1,
  parameter bit ROUND_HOLD = 1'b1,
  parameter int MID_W      = IN_W - LSB_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  din,
  output logic [MID_W-1:0] q
);

  localparam logic [MID_W-1:0] MID_MAX = {1'b0, {(MID_W-1){1'b1}}};
  localparam logic [IN_W-1:0]  IN_MAX  = {1'b0, {(IN_W-1){1'b1}}};

  logic [MID_W-1:0] nxt;

  generate
    if (LSB_W == 0) begin : g_pass
      assign nxt = din;
    end else begin : g_cut
      localparam logic [IN_W:0] HALF = (IN_W+1)'(1) << (LSB_W - 1);
      logic [IN_W:0]  ext;
      logic [IN_W:0]  bias;
      logic [IN_W:0]  sum;
      logic [MID_W:0] shf;
      logic           carry_ovf;
      always_comb begin
        ext       = {din[IN_W-1], din};
        bias      = din[IN_W-1] ? (HALF - 1'b1) : HALF;
        sum       = ROUND ? (ext + bias) : ext;
        shf       = sum[IN_W:LSB_W];
        carry_ovf = shf[MID_W] != shf[MID_W-1];
        nxt       = (ROUND_HOLD && carry_ovf) ? MID_MAX : shf[MID_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R5
  round_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ROUND && ROUND_HOLD && LSB_W > 0 && din == IN_MAX) |=> (q == MID_MAX));

endmodule

// File: rtl/rq_msb.sv
module rq_msb #(
  parameter int MID_W = 12,
  parameter int OUT_W = 8,
  parameter bit SAT   = 1'b1,
  parameter bit SYM   = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [MID_W-1:0] din,
  output logic [OUT_W-1:0] q
);

  localparam logic [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};
  localparam logic [OUT_W-1:0] ONEG = OMIN + 1'b1;

  logic             neg;
  logic             ovf;
  logic [OUT_W-1:0] low;
  logic [OUT_W-1:0] clipped;
  logic [OUT_W-1:0] nxt;

  generate
    if (OUT_W >= MID_W) begin : g_widen
      assign low = OUT_W'($signed(din));
      assign ovf = 1'b0;
    end else begin : g_narrow
      logic [MID_W-OUT_W:0] hi;
      assign hi  = din[MID_W-1:OUT_W-1];
      assign low = din[OUT_W-1:0];
      assign ovf = !((&hi) || !(|hi));
    end
  endgenerate

  always_comb begin
    neg = din[MID_W-1];
    if (ovf)                     clipped = neg ? (SYM ? ONEG : OMIN) : OMAX;
    else if (SYM && low == OMIN) clipped = ONEG;
    else                         clipped = low;
    nxt = SAT ? clipped : low;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= nxt;
  end

  // R7
  pos_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (SAT && !din[MID_W-1] && $signed(din) > $signed({{(MID_W > OUT_W ? 1 : 1){1'b0}}, din}) - $signed({1'b0, din}) + $signed({1'b0, MID_W'(OMAX)}))
      |=> (q == OMAX));

  // R8
  sym_floor_chk: assert property (@(posedge clk) disable iff (rst)
    (SAT && SYM) |-> (q != OMIN));

endmodule

// File: rtl/rq_lane.sv
module rq_lane #(
  parameter int IN_W       = 16,
  parameter int LSB_W      = 4,
  parameter int OUT_W      = 8,
  parameter bit ROUND      = 1'b1,
  parameter bit ROUND_HOLD = 1'b1,
  parameter bit SAT        = 1'b1,
  parameter bit SYM        = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  din,
  output logic [OUT_W-1:0] dout
);

  localparam int MID_W = IN_W - LSB_W;

  logic [MID_W-1:0] mid;

  rq_lsb #(
    .IN_W(IN_W), .LSB_W(LSB_W), .ROUND(ROUND), .ROUND_HOLD(ROUND_HOLD), .MID_W(MID_W)
  ) u_lsb (
    .clk(clk), .rst(rst), .din(din), .q(mid)
  );

  rq_msb #(
    .MID_W(MID_W), .OUT_W(OUT_W), .SAT(SAT), .SYM(SYM)
  ) u_msb (
    .clk(clk), .rst(rst), .din(mid), .q(dout)
  );

endmodule

// File: rtl/stream_requant.sv
module stream_requant
  import rq_pkg::*;
#(
  parameter int IN_W       = 16,
  parameter int LSB_W      = 4,
  parameter int OUT_W      = 8,
  parameter int SIDE_W     = 4,
  parameter bit COMPLEX    = 1'b1,
  parameter bit ROUND      = 1'b1,
  parameter bit ROUND_HOLD = 1'b1,
  parameter bit SAT        = 1'b1,
  parameter bit SYM        = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [IN_W-1:0]   in_re,
  input  logic [IN_W-1:0]   in_im,
  input  logic [SIDE_W-1:0] in_side,
  output logic              out_valid,
  output logic [OUT_W-1:0]  out_re,
  output logic [OUT_W-1:0]  out_im,
  output logic [SIDE_W-1:0] out_side
);

  localparam int LANES = rq_lanes(COMPLEX);
  localparam int DEPTH = 2;

  logic [LANES-1:0][IN_W-1:0]  lane_in;
  logic [LANES-1:0][OUT_W-1:0] lane_out;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      if (k == 0) begin : g_re
        assign lane_in[k] = in_re;
      end else begin : g_im
        assign lane_in[k] = in_im;
      end
      rq_lane #(
        .IN_W(IN_W), .LSB_W(LSB_W), .OUT_W(OUT_W), .ROUND(ROUND),
        .ROUND_HOLD(ROUND_HOLD), .SAT(SAT), .SYM(SYM)
      ) u_lane (
        .clk(clk), .rst(rst), .din(lane_in[k]), .dout(lane_out[k])
      );
    end
    if (COMPLEX) begin : g_cplx
      assign out_im = lane_out[LANES-1];
    end else begin : g_real
      assign out_im = '0;
    end
  endgenerate

  assign out_re = lane_out[0];

  logic [DEPTH-1:0]             v_pipe;
  logic [DEPTH-1:0][SIDE_W-1:0] s_pipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      v_pipe <= '0;
      s_pipe <= '0;
    end else begin
      v_pipe <= {v_pipe[DEPTH-2:0], in_valid};
      s_pipe <= {s_pipe[DEPTH-2:0], in_side};
    end
  end

  assign out_valid = v_pipe[DEPTH-1];
  assign out_side  = s_pipe[DEPTH-1];

  // R1
  valid_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

  // R1
  idle_lat_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |-> ##2 !out_valid);

  // R2
  side_lat_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 (out_side == $past(in_side, 2)));

endmodule

// File: tb/tb_stream_requant.sv
module tb_stream_requant;

  localparam int IN_W   = 16;
  localparam int LSB_W  = 4;
  localparam int OUT_W  = 8;
  localparam int SIDE_W = 4;
  localparam int MID_W  = IN_W - LSB_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              in_valid = 1'b0;
  logic [IN_W-1:0]   in_re = '0;
  logic [IN_W-1:0]   in_im = '0;
  logic [SIDE_W-1:0] in_side = '0;

  logic              a_v, b_v, c_v;
  logic [OUT_W-1:0]  a_re, a_im, b_re, b_im, c_re, c_im;
  logic [SIDE_W-1:0] a_s, b_s, c_s;

  // round + hold + asymmetric saturation
  stream_requant #(.IN_W(IN_W), .LSB_W(LSB_W), .OUT_W(OUT_W), .SIDE_W(SIDE_W),
    .COMPLEX(1'b1), .ROUND(1'b1), .ROUND_HOLD(1'b1), .SAT(1'b1), .SYM(1'b0)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im), .in_side(in_side),
    .out_valid(a_v), .out_re(a_re), .out_im(a_im), .out_side(a_s));

  // truncate + wrap (SYM set, must be ignored)
  stream_requant #(.IN_W(IN_W), .LSB_W(LSB_W), .OUT_W(OUT_W), .SIDE_W(SIDE_W),
    .COMPLEX(1'b1), .ROUND(1'b0), .ROUND_HOLD(1'b0), .SAT(1'b0), .SYM(1'b1)) dut_trunc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im), .in_side(in_side),
    .out_valid(b_v), .out_re(b_re), .out_im(b_im), .out_side(b_s));

  // round without hold + symmetric saturation
  stream_requant #(.IN_W(IN_W), .LSB_W(LSB_W), .OUT_W(OUT_W), .SIDE_W(SIDE_W),
    .COMPLEX(1'b1), .ROUND(1'b1), .ROUND_HOLD(1'b0), .SAT(1'b1), .SYM(1'b1)) dut_sym (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_re(in_re), .in_im(in_im), .in_side(in_side),
    .out_valid(c_v), .out_re(c_re), .out_im(c_im), .out_side(c_s));

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic int model(input int x, input bit rnd, input bit hold,
                               input bit sat, input bit sym);
    int h, mid, mmax, omax, omin, o;
    h    = 1 << (LSB_W - 1);
    mmax = (1 << (MID_W - 1)) - 1;
    omax = (1 << (OUT_W - 1)) - 1;
    omin = -(1 << (OUT_W - 1));
    if (rnd) mid = (x >= 0) ? ((x + h) >>> LSB_W) : ((x + h - 1) >>> LSB_W);
    else     mid = x >>> LSB_W;
    if (mid > mmax) mid = hold ? mmax : mid - (1 << MID_W);
    if (sat) begin
      if (mid > omax)                o = omax;
      else if (mid < omin)           o = sym ? -omax : omin;
      else if (sym && mid == omin)   o = -omax;
      else                           o = mid;
    end else begin
      o = mid & ((1 << OUT_W) - 1);
      if (o > omax) o = o - (1 << OUT_W);
    end
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // history of driven inputs: [0] newest, [1] due at the outputs now
  bit              hv[2];
  int              hre[2], him[2];
  logic [SIDE_W-1:0] hs[2];

  task automatic check_outputs();
    int e;
    chk(a_v == hv[1], "R1 valid dut", int'(a_v), int'(hv[1]));
    chk(b_v == hv[1], "R1 valid dut_trunc", int'(b_v), int'(hv[1]));
    chk(c_v == hv[1], "R1 valid dut_sym", int'(c_v), int'(hv[1]));
    if (hv[1]) begin
      chk(a_s == hs[1], "R2 side", int'(a_s), int'(hs[1]));
      chk(c_s == hs[1], "R2 side dut_sym", int'(c_s), int'(hs[1]));
      e = model(hre[1], 1, 1, 1, 0);
      chk($signed(a_re) == e, "R3 R5 R7 re", int'($signed(a_re)), e);
      e = model(him[1], 1, 1, 1, 0);
      chk($signed(a_im) == e, "R10 R3 R7 im", int'($signed(a_im)), e);
      e = model(hre[1], 0, 0, 0, 1);
      chk($signed(b_re) == e, "R4 R9 re", int'($signed(b_re)), e);
      e = model(him[1], 0, 0, 0, 1);
      chk($signed(b_im) == e, "R10 R4 R9 im", int'($signed(b_im)), e);
      e = model(hre[1], 1, 0, 1, 1);
      chk($signed(c_re) == e, "R6 R8 re", int'($signed(c_re)), e);
      e = model(him[1], 1, 0, 1, 1);
      chk($signed(c_im) == e, "R10 R6 R8 im", int'($signed(c_im)), e);
    end
  endtask

  task automatic step(input bit v, input int re, input int im, input logic [SIDE_W-1:0] s);
    @(negedge clk);
    check_outputs();
    hv[1] = hv[0]; hre[1] = hre[0]; him[1] = him[0]; hs[1] = hs[0];
    hv[0] = v; hre[0] = re; him[0] = im; hs[0] = s;
    in_valid = v;
    in_re    = IN_W'(re);
    in_im    = IN_W'(im);
    in_side  = s;
  endtask

  initial begin
    int dir[16];
    int seed;
    dir = '{32767, -32768, 0, 7, 8, -8, -9, 24, -24, 2039, 2040, -2040, -2056, 32760, 2047, -2048};
    seed = 17;
    void'($urandom(seed));
    hv[0] = 0; hv[1] = 0; hre = '{0, 0}; him = '{0, 0}; hs = '{0, 0};
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(a_v == 1'b0, "R1 reset valid", int'(a_v), 0);
    chk(a_re == '0, "R1 reset data", int'(a_re), 0);
    @(negedge clk);
    rst = 1'b0;
    // directed corners: round halves (R3), carry overflow (R5 R6),
    // saturation edges (R7 R8), wrap (R9), im gets a different corner (R10)
    foreach (dir[i]) step(1'b1, dir[i], dir[15 - i], SIDE_W'(i));
    step(1'b0, 0, 0, '0);
    step(1'b1, 32767, 32767, 4'hA);
    step(1'b0, 5, 5, 4'h5);
    // constrained random: mix of full-range and near-threshold values
    for (int n = 0; n < 600; n++) begin
      int r, m;
      bit v;
      v = ($urandom % 4) != 0;
      if ($urandom % 2) r = int'($urandom % 65536) - 32768;
      else              r = int'($urandom % 4200) - 2100;
      m = int'($urandom % 65536) - 32768;
      step(v, r, m, SIDE_W'($urandom));
    end
    step(1'b0, 0, 0, '0);
    step(1'b0, 0, 0, '0);
    step(1'b0, 0, 0, '0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule